// File: doc/BRIEF.md
# Ethernet MAC Link Speed Resolver

This block chooses the operating rate (10, 100 or 1000 Mb/s) of a MAC datapath. It listens to four possible sources and ranks them by strict priority. From highest to lowest they are a software value applied at once (bypass together with force), a software value applied through a quiesce-and-settle handshake (force alone), a rate measured from the PHY receive clock (auto-detect), and the rate the PHY reports when a link comes up. Control bits arrive from a register interface in the reference clock domain. The PHY rate indication and link flag are also synchronous to that clock. Only the PHY receive clock is foreign.

The forced path runs through a small sequencer with three states: IDLE, DRAIN and SETTLE. A request moves IDLE to DRAIN (transition START). DRAIN asks the datapath to quiesce for 8 reference cycles. DRAIN then moves to SETTLE (transition APPLY) while the new rate is written. SETTLE holds the busy flag for 8 more cycles and then returns to IDLE (transition DONE). A fresh request in any state restarts DRAIN (transition RESTART). Losing the force condition sends any state to IDLE (transition ABORT).

The rate meter divides the receive clock by 8 into a toggle, synchronises that toggle into the reference domain and counts its changes over fixed windows of reference cycles. A PHY-rate status field is always readable, whatever source is in control.

Top module: `link_speed_resolver`

## Requirements
- R1: Rates are coded as 2 bits: 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s. A software or PHY value of 11 is taken as 1000 Mb/s, and `mac_speed` never shows 11. With force on, a change of `sw_speed` between 10 and 11 does not start a new sequence.
- R2: While reset is held, and after it is released, `mac_speed` is 00 and `switch_busy` and `quiesce_req` are 0.
- R3: With `force_spd`=0 and `auto_det`=0, `mac_speed` takes the coded `phy_speed` one cycle after a cycle in which `phy_link` is 1 and was 0 in the previous cycle. A change of `phy_speed` at any other time leaves `mac_speed` unchanged.
- R4: `phy_speed_stat` always equals the `phy_speed` of the previous cycle, in every mode.
- R5: When `force_spd`=1 and `bypass_spd`=0, a sequence starts (IDLE to DRAIN) in the first cycle of that condition and in any cycle where the coded `sw_speed` differs from its value in the previous cycle. `quiesce_req` and `switch_busy` are then 1 for 8 cycles. At the end of those 8 cycles `mac_speed` takes the requested value and `quiesce_req` falls. `switch_busy` stays 1 for 8 further cycles.
- R6: A new request during DRAIN or SETTLE restarts DRAIN with the new value. The rate that was pending is never applied.
- R7: While `force_spd`=1, link-up events and rate-meter results do not change `mac_speed`, even when they disagree with the forced value.
- R8: When `force_spd`=1 and `bypass_spd`=1, `mac_speed` equals the coded `sw_speed` of the previous cycle. `switch_busy` and `quiesce_req` are 0, and any sequence in progress is dropped. `bypass_spd`=1 with `force_spd`=0 has no effect.
- R9: If `force_spd` falls during DRAIN, both flags clear in the next cycle and `mac_speed` is left unchanged.
- R10: Measurement windows are 1024 reference cycles long and start at reset release. The count is the number of toggle changes seen, where each toggle change stands for 8 receive-clock rising edges. At the end of a window a count of 96 or more gives 10, a count of 10 to 95 gives 01, and a count of 1 to 9 gives 00. With `auto_det`=1 and `force_spd`=0, this result is written one cycle after the window ends, and link-up events are ignored.
- R11: A window with no toggle changes leaves `mac_speed` at its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_spd | input | 1 | Software force of the rate |
| bypass_spd | input | 1 | With force: apply at once, skipping the handshake |
| auto_det | input | 1 | Enable the rate measured from the receive clock |
| sw_speed | input | 2 | Software rate value |
| phy_speed | input | 2 | Rate indication from the PHY |
| phy_link | input | 1 | PHY link-up flag |
| rx_clk | input | 1 | PHY receive clock |
| mac_speed | output | 2 | Resolved datapath rate |
| phy_speed_stat | output | 2 | Status copy of the PHY rate |
| switch_busy | output | 1 | Forced rate change in progress |
| quiesce_req | output | 1 | Request to quiesce the datapath |

## Verification
The PHY path is driven with rising link edges and with rate changes while the link stays high. This separates event-triggered loading from plain following. The forced path is tried with a lone request, with a request changed part-way through DRAIN, with a 10-to-11 rewrite, with bypass raised mid-sequence and with force dropped mid-sequence. These show the restart, no-request, abandon and abort transitions apart from the normal START/APPLY/DONE run. The receive clock is run at 125 MHz, 25 MHz and 2.5 MHz, switched just before a window boundary, and then stopped. These cases expose each classification band, the per-window timing and the hold on silence. Link-up events and forcing are mixed in during auto mode to confirm the ranking.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10
    } spd_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_DRAIN  = 2'b01,
        SEQ_SETTLE = 2'b10
    } seq_e;

    // Fold the unused code 11 onto the gigabit rate.
    function automatic spd_e code_to_spd(input logic [1:0] raw);
        spd_e s;
        case (raw)
            2'b00:   s = SPD_10;
            2'b01:   s = SPD_100;
            default: s = SPD_1000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lsr_rate_meter.sv
`timescale 1ns/1ps
module lsr_rate_meter
    import lsr_pkg::*;
#(
    parameter int WIN     = 1024,
    parameter int DIV     = 8,
    parameter int REF_MHZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    output logic det_valid,
    output spd_e det_speed
);
    localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int WW      = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CW      = $clog2(WIN + 1);
    // Band edges in toggle counts: about 75 MHz and 8 MHz of receive clock.
    localparam int TH_FAST = (WIN * 75) / (REF_MHZ * DIV);
    localparam int TH_MID  = (WIN * 8) / (REF_MHZ * DIV);

    // Receive-clock domain: divide down into a slow toggle.
    logic [DW-1:0] div_cnt;
    logic          rx_tog;

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            rx_tog  <= 1'b0;
        end else if (div_cnt == DW'(DIV - 1)) begin
            div_cnt <= '0;
            rx_tog  <= ~rx_tog;
        end else begin
            div_cnt <= div_cnt + DW'(1);
        end
    end

    // Reference domain: synchronise and detect toggle changes.
    logic [2:0]    sync_q;
    logic          tick;
    logic [WW-1:0] win_cnt;
    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] total;
    logic          win_end;
    spd_e          band;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], rx_tog};
    end

    assign tick    = sync_q[2] ^ sync_q[1];
    assign total   = edge_cnt + CW'(tick);
    assign win_end = (win_cnt == WW'(WIN - 1));

    always_comb begin
        if (total >= CW'(TH_FAST))     band = SPD_1000;
        else if (total >= CW'(TH_MID)) band = SPD_100;
        else                           band = SPD_10;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt   <= '0;
            edge_cnt  <= '0;
            det_valid <= 1'b0;
            det_speed <= SPD_10;
        end else if (win_end) begin
            win_cnt   <= '0;
            edge_cnt  <= '0;
            det_valid <= (total != '0);
            det_speed <= band;
        end else begin
            win_cnt   <= win_cnt + WW'(1);
            edge_cnt  <= total;
            det_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lsr_switch_seq.sv
`timescale 1ns/1ps
module lsr_switch_seq
    import lsr_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_en,
    input  spd_e req_speed,
    output logic busy,
    output logic quiesce,
    output logic apply,
    output spd_e target
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    seq_e          state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          force_q;
    spd_e          req_q;
    logic          request;
    logic          load;

    // A request is the first forced cycle or a change of the wanted rate.
    assign request = force_en && (!force_q || (req_speed != req_q));

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        load    = 1'b0;
        if (!force_en) begin
            state_n = SEQ_IDLE;                  // ABORT
            cnt_n   = '0;
        end else if (request) begin
            state_n = SEQ_DRAIN;                 // START / RESTART
            cnt_n   = '0;
            load    = 1'b1;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt_n = '0;
                end
                SEQ_DRAIN: begin
                    if (cnt == LAST) begin
                        state_n = SEQ_SETTLE;    // APPLY
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt == LAST) begin
                        state_n = SEQ_IDLE;      // DONE
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                default: begin
                    state_n = SEQ_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            force_q <= 1'b0;
            req_q   <= SPD_10;
            target  <= SPD_10;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            force_q <= force_en;
            req_q   <= req_speed;
            if (load) target <= req_speed;
        end
    end

    always_comb begin
        busy    = (state != SEQ_IDLE);
        quiesce = (state == SEQ_DRAIN);
        apply   = force_en && !request && (state == SEQ_DRAIN) && (cnt == LAST);
    end

endmodule

// File: rtl/link_speed_resolver.sv
`timescale 1ns/1ps
module link_speed_resolver
    import lsr_pkg::*;
#(
    parameter int WIN     = 1024,
    parameter int DIV     = 8,
    parameter int REF_MHZ = 100,
    parameter int HOLD    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_spd,
    input  logic       bypass_spd,
    input  logic       auto_det,
    input  logic [1:0] sw_speed,
    input  logic [1:0] phy_speed,
    input  logic       phy_link,
    input  logic       rx_clk,
    output logic [1:0] mac_speed,
    output logic [1:0] phy_speed_stat,
    output logic       switch_busy,
    output logic       quiesce_req
);
    logic force_eff, bypass_eff;
    logic det_valid, apply, link_q;
    spd_e det_speed, target, sw_code, spd_q, spd_n;

    assign force_eff  = force_spd && !bypass_spd;
    assign bypass_eff = force_spd && bypass_spd;
    assign sw_code    = code_to_spd(sw_speed);

    lsr_rate_meter #(
        .WIN     (WIN),
        .DIV     (DIV),
        .REF_MHZ (REF_MHZ)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_clk    (rx_clk),
        .det_valid (det_valid),
        .det_speed (det_speed)
    );

    lsr_switch_seq #(
        .HOLD (HOLD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_en  (force_eff),
        .req_speed (sw_code),
        .busy      (switch_busy),
        .quiesce   (quiesce_req),
        .apply     (apply),
        .target    (target)
    );

    // Strict ranking of the four sources.
    always_comb begin
        spd_n = spd_q;
        if (bypass_eff) begin
            spd_n = sw_code;
        end else if (force_eff) begin
            if (apply) spd_n = target;
        end else if (auto_det) begin
            if (det_valid) spd_n = det_speed;
        end else if (phy_link && !link_q) begin
            spd_n = code_to_spd(phy_speed);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_q  <= SPD_10;
            link_q <= 1'b0;
        end else begin
            spd_q  <= spd_n;
            link_q <= phy_link;
        end
    end

    // Status copy runs in every mode, reset or not.
    always_ff @(posedge clk) begin
        phy_speed_stat <= phy_speed;
    end

    assign mac_speed = spd_q;

endmodule

// File: rtl/lsr_checker.sv
`timescale 1ns/1ps
module lsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       force_spd,
    input logic       bypass_spd,
    input logic [1:0] sw_speed,
    input logic [1:0] phy_speed,
    input logic [1:0] mac_speed,
    input logic [1:0] phy_speed_stat,
    input logic       switch_busy,
    input logic       quiesce_req
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_speed_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mac_speed != 2'b11);

    a_r4_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> phy_speed_stat == $past(phy_speed));

    a_r5_quiesce_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        quiesce_req |-> switch_busy);

    a_r5_start_drains: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_busy) |-> quiesce_req);

    a_r5_apply_at_drain_end: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(force_spd && !bypass_spd) && (mac_speed != $past(mac_speed)))
        |-> $fell(quiesce_req));

    a_r8_bypass_now: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(force_spd && bypass_spd))
        |-> (mac_speed == (($past(sw_speed) == 2'b11) ? 2'b10 : $past(sw_speed))) && !switch_busy);

endmodule

bind link_speed_resolver lsr_checker i_lsr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .force_spd      (force_spd),
    .bypass_spd     (bypass_spd),
    .sw_speed       (sw_speed),
    .phy_speed      (phy_speed),
    .mac_speed      (mac_speed),
    .phy_speed_stat (phy_speed_stat),
    .switch_busy    (switch_busy),
    .quiesce_req    (quiesce_req)
);

// File: tb/test_link_speed_resolver.sv
`timescale 1ns/1ps
module test_link_speed_resolver;
    localparam int W = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       force_spd = 1'b0, bypass_spd = 1'b0, auto_det = 1'b0;
    logic [1:0] sw_speed = 2'b00, phy_speed = 2'b00;
    logic       phy_link = 1'b0;
    logic       rx_clk = 1'b0;
    logic [1:0] mac_speed, phy_speed_stat;
    logic       switch_busy, quiesce_req;

    int    rx_half = 200;
    int    compared = 0, mismatched = 0;
    string cur_req = "R2";
    logic  done = 1'b0;

    always #5 clk = ~clk;

    always begin
        if (rx_half == 0) begin
            rx_clk = 1'b0;
            @(posedge clk);
        end else begin
            #(rx_half);
            rx_clk = ~rx_clk;
        end
    end

    link_speed_resolver i_link_speed_resolver (
        .clk            (clk),
        .rst_n          (rst_n),
        .force_spd      (force_spd),
        .bypass_spd     (bypass_spd),
        .auto_det       (auto_det),
        .sw_speed       (sw_speed),
        .phy_speed      (phy_speed),
        .phy_link       (phy_link),
        .rx_clk         (rx_clk),
        .mac_speed      (mac_speed),
        .phy_speed_stat (phy_speed_stat),
        .switch_busy    (switch_busy),
        .quiesce_req    (quiesce_req)
    );

    // ---------------- reference model ----------------
    function automatic logic [1:0] fold(input logic [1:0] v);
        return (v == 2'b11) ? 2'b10 : v;
    endfunction

    function automatic int band_of(input int half);
        if (half == 0)  return -1;
        if (half <= 5)  return 2;
        if (half <= 25) return 1;
        return 0;
    endfunction

    int         k = 0, m_phase = 0, m_cnt = 0, win_cls = 0, pend_cls = 0;
    logic       m_pend = 1'b0, m_feff_q = 1'b0, m_link_q = 1'b0;
    logic [1:0] m_spd = 2'b00, m_stat = 2'b00, m_tgt = 2'b00, m_sw_q = 2'b00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k = 0; m_phase = 0; m_cnt = 0; m_pend = 0; m_feff_q = 0; m_link_q = 0;
            m_spd = 2'b00; m_tgt = 2'b00; m_sw_q = 2'b00;
            win_cls = band_of(rx_half);
            m_stat = phy_speed;
        end else begin
            logic       feff, beff, req, app;
            logic [1:0] swn, nspd;
            feff = force_spd && !bypass_spd;
            beff = force_spd && bypass_spd;
            swn  = fold(sw_speed);
            req  = feff && (!m_feff_q || swn != m_sw_q);
            app  = feff && !req && m_phase == 1 && m_cnt == 7;
            nspd = m_spd;
            if (beff) nspd = swn;
            else if (feff) begin if (app) nspd = m_tgt; end
            else if (auto_det) begin if (m_pend) nspd = 2'(pend_cls); end
            else if (phy_link && !m_link_q) nspd = fold(phy_speed);
            if (!feff) begin m_phase = 0; m_cnt = 0; end
            else if (req) begin m_phase = 1; m_cnt = 0; m_tgt = swn; end
            else if (m_phase == 1) begin
                if (m_cnt == 7) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_phase == 2) begin
                if (m_cnt == 7) begin m_phase = 0; m_cnt = 0; end else m_cnt++;
            end
            k++;
            if (k % W == 0) begin
                m_pend   = (win_cls != -1);
                pend_cls = win_cls;
                win_cls  = band_of(rx_half);
            end else m_pend = 0;
            m_spd = nspd; m_feff_q = feff; m_sw_q = swn;
            m_link_q = phy_link; m_stat = phy_speed;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (mac_speed !== m_spd || switch_busy !== (m_phase != 0) ||
                quiesce_req !== (m_phase == 1) || phy_speed_stat !== m_stat) begin
                mismatched++;
                $display("FAIL %s cycle %0d: actual spd=%b busy=%b q=%b stat=%b expected spd=%b busy=%b q=%b stat=%b",
                         cur_req, k, mac_speed, switch_busy, quiesce_req, phy_speed_stat,
                         m_spd, (m_phase != 0), (m_phase == 1), m_stat);
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // {mac_speed, busy, quiesce} packed for explicit checks
    function automatic logic [3:0] obs();
        return {mac_speed, switch_busy, quiesce_req};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_offset(input int off);
        while (k % W != off) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        chk("R2 in reset", obs(), 4'b0000);
        rst_n = 1'b1;
        cyc(2);
        chk("R2 after release", obs(), 4'b0000);

        // PHY link-up path
        cur_req = "R3"; phy_speed = 2'b01; cyc(2);
        chk("R4 status", {2'b00, phy_speed_stat}, 4'b0001);
        phy_link = 1'b1; cyc(1);
        chk("R3 link-up load", obs(), 4'b0100);
        phy_speed = 2'b10; cyc(4);
        chk("R3 no load while link held", obs(), 4'b0100);
        cur_req = "R1"; phy_link = 1'b0; phy_speed = 2'b11; cyc(2);
        phy_link = 1'b1; cyc(1);
        chk("R1 code 11 folded", obs(), 4'b1000);

        // forced sequence
        cur_req = "R5"; force_spd = 1'b1; sw_speed = 2'b00; cyc(1);
        chk("R5 drain entered", obs(), 4'b1011);
        cyc(7);
        chk("R5 still draining", obs(), 4'b1011);
        cyc(1);
        chk("R5 applied, settling", obs(), 4'b0010);
        cyc(8);
        chk("R5 done", obs(), 4'b0000);
        cur_req = "R6"; sw_speed = 2'b01; cyc(5);
        sw_speed = 2'b10; cyc(4);
        chk("R6 pending value not applied", obs(), 4'b0011);
        cyc(5);
        chk("R6 restarted drain applies new value", obs(), 4'b1010);
        cyc(10);
        cur_req = "R1"; sw_speed = 2'b11; cyc(2);
        chk("R1 10 to 11 makes no request", obs(), 4'b1000);
        cur_req = "R7"; phy_speed = 2'b01; phy_link = 1'b0; cyc(2); phy_link = 1'b1; cyc(3);
        chk("R7 link-up ignored under force", obs(), 4'b1000);

        // bypass
        cur_req = "R8"; bypass_spd = 1'b1; sw_speed = 2'b01; cyc(1);
        chk("R8 immediate", obs(), 4'b0100);
        bypass_spd = 1'b0; cyc(4);
        sw_speed = 2'b00; bypass_spd = 1'b1; cyc(1);
        chk("R8 sequence dropped", obs(), 4'b0000);
        cur_req = "R9"; sw_speed = 2'b10; bypass_spd = 1'b0; cyc(3);
        force_spd = 1'b0; cyc(1);
        chk("R9 abort keeps rate", obs(), 4'b0000);
        cur_req = "R8"; bypass_spd = 1'b1; phy_speed = 2'b01; phy_link = 1'b0; cyc(2);
        phy_link = 1'b1; cyc(1);
        chk("R8 bypass alone ignored", obs(), 4'b0100);
        bypass_spd = 1'b0; cyc(2);

        // auto detection
        cur_req = "R10"; auto_det = 1'b1;
        to_offset(W - 20); rx_half = 4;
        cyc(2 * W + 10);
        chk("R10 fast band", obs(), 4'b1000);
        phy_link = 1'b0; phy_speed = 2'b00; cyc(2); phy_link = 1'b1; cyc(2);
        chk("R10 link-up ignored", obs(), 4'b1000);
        to_offset(W - 20); rx_half = 20;
        cyc(2 * W + 10);
        chk("R10 mid band", obs(), 4'b0100);
        cur_req = "R7"; force_spd = 1'b1; sw_speed = 2'b10; cyc(W + 40);
        chk("R7 detection ignored under force", obs(), 4'b1000);
        force_spd = 1'b0;
        cur_req = "R10"; to_offset(W - 20); rx_half = 200;
        cyc(2 * W + 10);
        chk("R10 slow band", obs(), 4'b0000);
        to_offset(W - 20); rx_half = 4;
        cyc(2 * W + 10);
        chk("R10 back to fast", obs(), 4'b1000);
        cur_req = "R11"; to_offset(W - 20); rx_half = 0;
        cyc(3 * W + 10);
        chk("R11 silence holds rate", obs(), 4'b1000);

        finish_run();
    end

endmodule